// File: doc/BRIEF.md
# Flash Program/Erase Engine with Status Polling

This block is the embedded-operation engine of a byte-wide flash, together with the status reporting on its read path. A start request names one of three operations: program one byte, erase one block, or erase the whole chip. An accepted request raises `busy` and starts a cycle-count timer. The timer length is a parameter, with a short count for a program and a long one for either kind of erase. When the timer runs out, the engine applies the operation to a register-backed array and drops `busy`. The array is then in read mode again, with no further command.

While an operation runs, reads do not return array contents. They return a status byte. Software can poll bit 7, which differs from the final value until the operation is done. Software can also watch bit 6, which alternates on every status read until the operation is done. The status byte for a program differs from the one for an erase. One block of the array is the boot block. A lock input protects it from program and block-erase requests, and from a chip erase that starts while the lock is high.

With the default parameters the array holds 256 bytes in four 64-byte blocks. The block index is `addr[7:6]`, and the boot block is block 3 (addresses C0h to FFh).

Top module: `flash_busy_poll`

## Requirements
- R1: After reset, `busy` is 0 and every byte of the array reads FFh.
- R2: An accepted start sets `busy` at the next clock edge. `busy` then stays high for exactly PROG_CYC cycles for a program (`startOp`=00) and exactly ERASE_CYC cycles for a block erase (01) or a chip erase (10). The array changes at the edge where `busy` falls.
- R3: A start that arrives while `busy` is high is ignored, and so is `startOp`=11. Neither changes the array or the busy period.
- R4: A program leaves the addressed byte as old AND new, so it can only clear bits.
- R5: A block erase sets every byte whose `addr[7:6]` matches the request to FFh. It leaves every other byte unchanged.
- R6: A chip erase sets all bytes to FFh, except that the boot block (`addr[7:6]`=3) is left unchanged when `bootLock` is high at the start.
- R7: While `bootLock` is high, a program or block erase that targets the boot block is rejected. `busy` stays 0 and the array is unchanged.
- R8: A read sampled while a program is busy returns bit 7 as the complement of bit 7 of the data being programmed.
- R9: A read sampled while an erase is busy returns bit 7 as 0. After the erase completes, reads of erased bytes return FFh, so bit 7 reads 1.
- R10: Within one operation, bit 6 of successive status reads alternates. The first status read after each start returns 0.
- R11: A status read returns 0 on bits 5 to 0.
- R12: `rdData` is registered. A read requested in one cycle appears after the next edge and holds while `rdEn` is low. Once `busy` is low, reads return the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startValid | input | 1 | Start request strobe |
| startOp | input | 2 | 00 program, 01 block erase, 10 chip erase, 11 none |
| startAddr | input | ADDR_W | Byte address for a program, or any address inside the block to erase |
| startData | input | 8 | Byte to program |
| bootLock | input | 1 | Boot block protection, sampled at start |
| rdEn | input | 1 | Read request |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | 8 | Read result or status byte |
| busy | output | 1 | Operation in progress |

## Verification
The checker watches every status read on every cycle. It checks that bit 7 follows the kind of operation, that bits 5 to 0 are zero, and that bit 6 alternates between reads of one operation. It also checks that `busy` never rises without a valid start and never outlasts the longer timer. The bench is the only place that shows the array contents after each operation: the AND rule for programs, the exact range of a block erase, the boot block kept through a locked chip erase, and starts that had no effect. It also measures the exact busy length and the reset of the toggle bit to 0 at each start.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    OP_PROG   = 2'b00,
    OP_BERASE = 2'b01,
    OP_CERASE = 2'b10,
    OP_NONE   = 2'b11
  } opKind_t;

  typedef struct packed {
    logic capture;
    logic commit;
    logic busy;
  } ctlStrobe_t;
endpackage

// File: rtl/flash_poll_ctl.sv
module flash_poll_ctl
  import flash_poll_pkg::*;
#(
  parameter int BLK_BITS  = 2,
  parameter int BOOT_IDX  = 3,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startValid,
  input  logic [1:0]          startOp,
  input  logic [BLK_BITS-1:0] startBlk,
  input  logic                bootLock,
  output ctlStrobe_t          strobe
);
  localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  opKind_t            reqOp;
  logic               bootTarget;
  logic               legal;
  logic               accept;
  logic               busyQ;
  logic [CNT_W-1:0]   cntQ;

  always_comb begin
    reqOp      = opKind_t'(startOp);
    bootTarget = (startBlk == BLK_BITS'(BOOT_IDX));
    legal      = (reqOp != OP_NONE) &&
                 !(bootLock && bootTarget && (reqOp != OP_CERASE));
    accept     = startValid && !busyQ && legal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
    end else if (accept) begin
      busyQ <= 1'b1;
      cntQ  <= (reqOp == OP_PROG) ? CNT_W'(PROG_CYC - 1) : CNT_W'(ERASE_CYC - 1);
    end else if (busyQ) begin
      if (cntQ == '0) busyQ <= 1'b0;
      else            cntQ  <= cntQ - 1'b1;
    end
  end

  always_comb begin
    strobe.capture = accept;
    strobe.commit  = busyQ && (cntQ == '0);
    strobe.busy    = busyQ;
  end
endmodule

// File: rtl/flash_poll_dp.sv
module flash_poll_dp
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BLK_BITS = 2,
  parameter int BOOT_IDX = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [1:0]        startOp,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] startData,
  input  logic              bootLock,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  opKind_t           opQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic              lockQ;
  logic              toggleQ;
  logic [DEPTH-1:0]  hitVec;
  logic              statBit7;

  // One hit flag per byte: does the pending operation touch it?
  for (genvar g = 0; g < DEPTH; g++) begin : g_hit
    localparam logic [ADDR_W-1:0] ADR = ADDR_W'(g);
    logic sameBlk;
    logic inBoot;
    assign sameBlk = (addrQ[ADDR_W-1 -: BLK_BITS] == ADR[ADDR_W-1 -: BLK_BITS]);
    assign inBoot  = (ADR[ADDR_W-1 -: BLK_BITS] == BLK_BITS'(BOOT_IDX));
    always_comb begin
      unique case (opQ)
        OP_PROG:   hitVec[g] = (addrQ == ADR);
        OP_BERASE: hitVec[g] = sameBlk;
        OP_CERASE: hitVec[g] = !(lockQ && inBoot);
        default:   hitVec[g] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ   <= OP_NONE;
      addrQ <= '0;
      dataQ <= '0;
      lockQ <= 1'b0;
    end else if (strobe.capture) begin
      opQ   <= opKind_t'(startOp);
      addrQ <= startAddr;
      dataQ <= startData;
      lockQ <= bootLock;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (strobe.commit) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (hitVec[i]) mem[i] <= (opQ == OP_PROG) ? (mem[i] & dataQ) : '1;
      end
    end
  end

  assign statBit7 = (opQ == OP_PROG) ? ~dataQ[DATA_W-1] : 1'b0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      toggleQ <= 1'b0;
    end else begin
      if (strobe.capture) toggleQ <= 1'b0;
      if (rdEn) begin
        if (strobe.busy) begin
          rdData  <= {statBit7, toggleQ, {(DATA_W-2){1'b0}}};
          toggleQ <= ~toggleQ;
        end else begin
          rdData  <= mem[rdAddr];
        end
      end
    end
  end
endmodule

// File: rtl/flash_busy_poll.sv
module flash_busy_poll
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_BLK   = 4,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [1:0]        startOp,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [7:0]        startData,
  input  logic              bootLock,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              busy
);
  localparam int BLK_BITS = $clog2(NUM_BLK);
  localparam int BOOT_IDX = NUM_BLK - 1;

  ctlStrobe_t strobe;

  flash_poll_ctl #(
    .BLK_BITS(BLK_BITS), .BOOT_IDX(BOOT_IDX),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startOp(startOp),
    .startBlk(startAddr[ADDR_W-1 -: BLK_BITS]), .bootLock(bootLock),
    .strobe(strobe)
  );

  flash_poll_dp #(
    .ADDR_W(ADDR_W), .BLK_BITS(BLK_BITS), .BOOT_IDX(BOOT_IDX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startOp(startOp),
    .startAddr(startAddr), .startData(startData), .bootLock(bootLock),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

  assign busy = strobe.busy;
endmodule

// File: rtl/flash_poll_chk.sv
module flash_poll_chk #(
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 20
) (
  input logic       clk,
  input logic       rstN,
  input logic       startValid,
  input logic [1:0] startOp,
  input logic       dataBit7,
  input logic       rdEn,
  input logic [7:0] rdData,
  input logic       busy
);
  localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;

  int         busyLenQ;
  logic [1:0] opSeenQ;
  logic       dataSeenQ;
  logic       statRdQ;
  logic       prevValidQ;
  logic       prevTogQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyLenQ   <= 0;
      opSeenQ    <= 2'b11;
      dataSeenQ  <= 1'b0;
      statRdQ    <= 1'b0;
      prevValidQ <= 1'b0;
      prevTogQ   <= 1'b0;
    end else begin
      busyLenQ <= busy ? busyLenQ + 1 : 0;
      statRdQ  <= rdEn && busy;
      if (startValid && !busy) begin
        opSeenQ    <= startOp;
        dataSeenQ  <= dataBit7;
        prevValidQ <= 1'b0;
      end else if (statRdQ) begin
        prevValidQ <= 1'b1;
        prevTogQ   <= rdData[6];
      end else if (!busy) begin
        prevValidQ <= 1'b0;
      end
    end
  end

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> busyLenQ < MAX_CYC); // R2
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(startValid) && $past(startOp) != 2'b11)); // R3
  AST_PROG_BIT7: assert property (@(posedge clk) disable iff (!rstN)
    (statRdQ && opSeenQ == 2'b00) |-> (rdData[7] == ~dataSeenQ)); // R8
  AST_ERASE_BIT7: assert property (@(posedge clk) disable iff (!rstN)
    (statRdQ && opSeenQ != 2'b00) |-> !rdData[7]); // R9
  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rstN)
    (statRdQ && prevValidQ) |-> (rdData[6] != prevTogQ)); // R10
  AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    statRdQ |-> (rdData[5:0] == 6'd0)); // R11
endmodule

bind flash_busy_poll flash_poll_chk #(
  .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
) u_chk (
  .clk(clk), .rstN(rstN), .startValid(startValid), .startOp(startOp),
  .dataBit7(startData[7]), .rdEn(rdEn), .rdData(rdData), .busy(busy)
);

// File: tb/sim_flash_busy_poll.sv
module sim_flash_busy_poll;
  localparam int PROG_CYC  = 4;
  localparam int ERASE_CYC = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startValid = 1'b0;
  logic [1:0] startOp = 2'b11;
  logic [7:0] startAddr = '0;
  logic [7:0] startData = '0;
  logic       bootLock = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model [256];

  always #4 clk = ~clk;

  flash_busy_poll #(.ADDR_W(8), .NUM_BLK(4), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u0 (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startOp(startOp),
    .startAddr(startAddr), .startData(startData), .bootLock(bootLock),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expStat(input logic [1:0] op, input logic [7:0] d, input int k);
    return {(op == 2'b00) ? ~d[7] : 1'b0, k[0], 6'b0};
  endfunction

  function automatic bit expAccept(input logic [1:0] op, input logic [7:0] a, input logic lk);
    return (op != 2'b11) && !(lk && op != 2'b10 && a[7:6] == 2'd3);
  endfunction

  task automatic applyModel(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d, input logic lk);
    for (int i = 0; i < 256; i++) begin
      logic [7:0] ia;
      ia = 8'(i);
      case (op)
        2'b00: if (ia == a) model[i] = model[i] & d;
        2'b01: if (ia[7:6] == a[7:6]) model[i] = 8'hFF;
        2'b10: if (!(lk && ia[7:6] == 2'd3)) model[i] = 8'hFF;
        default: ;
      endcase
    end
  endtask

  task automatic rdCheck(input logic [7:0] a, input string req);
    rdEn = 1'b1; rdAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
    check(rdData == model[a], req, rdData, model[a]);
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 256; i++) rdCheck(8'(i), req);
  endtask

  task automatic doOp(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d,
                      input logic lk, input bit inject);
    bit acc, pend;
    int n, k, cnt;
    acc = expAccept(op, a, lk);
    n = (op == 2'b00) ? PROG_CYC : ERASE_CYC;
    startValid = 1'b1; startOp = op; startAddr = a; startData = d; bootLock = lk;
    @(negedge clk);
    startValid = 1'b0;
    if (op == 2'b11) check(busy == 1'b0, "R3 busy for op 11", busy, 0);
    else if (!acc)   check(busy == 1'b0, "R7 busy for locked target", busy, 0);
    else             check(busy == 1'b1, "R2 busy after start", busy, 1);
    k = 0; cnt = 0; pend = 0;
    while (busy && cnt <= n) begin
      if (pend) begin
        check(rdData == expStat(op, d, k), "R8 R9 R10 R11 status", rdData, expStat(op, d, k));
        k++;
      end
      if (inject && cnt == 1) begin
        startValid = 1'b1; startOp = 2'b10; startAddr = 8'h00; bootLock = 1'b0;
      end else begin
        startValid = 1'b0;
      end
      cnt++;
      pend = ($urandom_range(0, 1) == 1);
      rdEn = pend; rdAddr = 8'($urandom);
      @(negedge clk);
    end
    startValid = 1'b0;
    if (pend) check(rdData == expStat(op, d, k), "R8 R9 R10 R11 last status", rdData, expStat(op, d, k));
    rdEn = 1'b0;
    if (acc) begin
      check(cnt == n, "R2 busy length", cnt, n);
      applyModel(op, a, d, lk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    sweep("R1 erased after reset");

    // R4: program twice to the same byte
    doOp(2'b00, 8'h10, 8'hA5, 1'b0, 0);
    rdCheck(8'h10, "R4 first program");
    doOp(2'b00, 8'h10, 8'h3C, 1'b0, 0);
    rdCheck(8'h10, "R4 AND of old and new");
    check(model[8'h10] == 8'h24, "R4 model value", model[8'h10], 8'h24);
    // R12: held output while rdEn is low
    repeat (3) @(negedge clk);
    check(rdData == 8'h24, "R12 rdData holds", rdData, 8'h24);

    // R3: start during busy, then op 11
    doOp(2'b00, 8'h50, 8'h00, 1'b0, 1);
    sweep("R3 start while busy ignored");
    doOp(2'b11, 8'h00, 8'h00, 1'b0, 0);
    sweep("R3 op 11 ignored");

    // R5 and R9: block erase of block 0
    doOp(2'b01, 8'h12, 8'h00, 1'b0, 0);
    rdCheck(8'h10, "R9 bit7 high after erase");
    check(rdData[7] == 1'b1, "R9 bit7 after erase", rdData[7], 1);
    sweep("R5 block erase range");

    // R7: locked boot block
    doOp(2'b00, 8'hF0, 8'h0F, 1'b0, 0);
    doOp(2'b00, 8'hF0, 8'h00, 1'b1, 0);
    rdCheck(8'hF0, "R7 locked program ignored");
    doOp(2'b01, 8'hC3, 8'h00, 1'b1, 0);
    rdCheck(8'hF0, "R7 locked block erase ignored");

    // R6: chip erase with lock keeps boot block
    doOp(2'b00, 8'h20, 8'h11, 1'b0, 0);
    doOp(2'b10, 8'h00, 8'h00, 1'b1, 0);
    rdCheck(8'hF0, "R6 boot kept");
    check(rdData == 8'h0F, "R6 boot byte", rdData, 8'h0F);
    rdCheck(8'h20, "R6 other erased");
    doOp(2'b10, 8'h00, 8'h00, 1'b0, 0);
    sweep("R6 unlocked chip erase");

    // Random mix
    for (int t = 0; t < 60; t++) begin
      logic [1:0] op;
      logic [7:0] a, d;
      int r;
      r = $urandom_range(0, 9);
      op = (r < 6) ? 2'b00 : (r < 8) ? 2'b01 : (r < 9) ? 2'b10 : 2'b11;
      a = 8'($urandom);
      d = 8'($urandom);
      doOp(op, a, d, ($urandom_range(0, 3) == 0), ($urandom_range(0, 4) == 0));
      rdCheck(a, "R12 random target read");
      rdCheck(8'($urandom), "R12 random read");
    end
    sweep("R12 final contents");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule